// File: doc/BRIEF.md
# Fine-Resolution PWM with Cycle Stretching

This block produces a single pulse-width modulated waveform with 14 bits of effective resolution. Each PWM cycle is 256 clocks long and its output is driven high for a coarse duty count taken from an 8-bit register. A 6-bit fine value then adds exactly one clock of high time to a chosen subset of 64 consecutive cycles. Averaged over those 64 cycles, the output interpolates between adjacent coarse duty settings in steps of 1/64 of a clock.

Software writes the two values through a one-byte write port. A write with the select bit high only parks the fine value in a holding buffer. A write with the select bit low places the coarse duty and the parked fine value in a pending slot. A two-state load controller, with states `LD_EMPTY` and `LD_ARMED`, moves the pending pair into the active registers on the last clock of the current PWM cycle. The waveform therefore never shows a mixture of old and new settings inside one cycle.

Load controller transitions:
- `LD_EMPTY` → `LD_ARMED` when the coarse duty is written on any clock other than the last one of a cycle.
- `LD_ARMED` → `LD_EMPTY` on the last clock of a cycle, when the pending pair is committed.
- `LD_EMPTY` stays `LD_EMPTY` when the coarse duty is written on the last clock of a cycle. In that case the written value and the buffer are committed at once.

Top module: `pwm_brm`

## Requirements
- R1: After reset the counters, the active registers, the pending slot and the buffer are all zero, so `pwm_out` stays low until a coarse duty is loaded.
- R2: A PWM cycle lasts 256 clocks. `pwm_out` is high from clock 0 of the cycle for `duty` clocks and low for the rest, where `duty` is the active coarse value.
- R3: With an active coarse value of 0, the output is low for the whole cycle when the cycle is not stretched, and high only on clock 0 when it is stretched.
- R4: Cycles are numbered c = 0..63. Bit k of the active fine value adds one high clock, placed directly after the coarse high time, in every cycle whose lowest set bit is at position 5-k. Bit 0 therefore selects cycle 32 and bit 5 selects every odd cycle. Cycle 0 is never stretched.
- R5: The cycle number wraps from 63 to 0, so the stretch pattern repeats every 64 cycles.
- R6: A write with `wr_sel`=1 stores `wr_data[5:0]` in the holding buffer only. The output does not change, including over the following full cycle.
- R7: A write with `wr_sel`=0 sets both the coarse duty (`wr_data`) and the buffered fine value as one pending pair. The rest of the current cycle keeps the old settings, and the new pair governs from the next cycle start.
- R8: A coarse write on clock 255 of a cycle takes effect in the immediately following cycle.
- R9: A coarse value of 255 in a stretched cycle holds the output high for all 256 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counters and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the byte port |
| wr_sel | input | 1 | 0 selects the coarse duty, 1 selects the fine buffer |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Modulated waveform |

## Verification
The bench sweeps each fine bit on its own through a full 64-cycle frame and compares every output clock against an arithmetic stretch schedule. A wrong decode would put the extra clock in the wrong cycles, and an off-by-one would stretch cycle 0. Two cases target the load timing. In the first, a fine-only write must leave the waveform untouched. In the second, a coarse write in the middle of a cycle must not alter that cycle's remainder. An early commit would produce a torn cycle, and a missing commit would leave the old duty in place. The extremes are also covered: a coarse value of 0 stretched to a single clock, a coarse value of 255 stretched to a solid high cycle, a write on the final clock of a cycle, and a run across the 63-to-0 wrap.

// File: rtl/pwm_brm_pkg.sv
package pwm_brm_pkg;

    typedef enum logic {
        LD_EMPTY = 1'b0,
        LD_ARMED = 1'b1
    } ld_state_e;

endpackage

// File: rtl/pwm_brm_timebase.sv
module pwm_brm_timebase #(
    parameter int CNT_W = 8,
    parameter int CYC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic [CYC_W-1:0] cyc,
    output logic             last_clk
);

    assign last_clk = &cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            cyc <= '0;
        end else begin
            cnt <= cnt + 1'b1;
            if (last_clk) begin
                cyc <= cyc + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_brm_loader.sv
module pwm_brm_loader
    import pwm_brm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int CYC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             last_clk,
    output logic [CNT_W-1:0] duty_q,
    output logic [CYC_W-1:0] brm_q
);

    ld_state_e        state_q, state_d;
    logic             wr_duty, wr_fine, commit;
    logic [CYC_W-1:0] fine_buf;
    logic [CNT_W-1:0] pend_duty;
    logic [CYC_W-1:0] pend_brm;

    assign wr_duty = wr_en && !wr_sel;
    assign wr_fine = wr_en && wr_sel;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and commit decision
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            LD_EMPTY: begin
                if (wr_duty) begin
                    if (last_clk) begin
                        commit = 1'b1;
                    end else begin
                        state_d = LD_ARMED;
                    end
                end
            end
            LD_ARMED: begin
                if (last_clk) begin
                    commit  = 1'b1;
                    state_d = LD_EMPTY;
                end
            end
            default: state_d = LD_EMPTY;
        endcase
    end

    // data registers driven by the controller
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_buf  <= '0;
            pend_duty <= '0;
            pend_brm  <= '0;
            duty_q    <= '0;
            brm_q     <= '0;
        end else begin
            if (wr_fine) begin
                fine_buf <= wr_data[CYC_W-1:0];
            end
            if (wr_duty) begin
                pend_duty <= wr_data;
                pend_brm  <= fine_buf;
            end
            if (commit) begin
                duty_q <= wr_duty ? wr_data  : pend_duty;
                brm_q  <= wr_duty ? fine_buf : pend_brm;
            end
        end
    end

endmodule

// File: rtl/pwm_brm_pattern.sv
module pwm_brm_pattern #(
    parameter int CYC_W = 6
) (
    input  logic [CYC_W-1:0] cyc,
    input  logic [CYC_W-1:0] brm,
    output logic             stretch
);

    logic [CYC_W-1:0] hit;

    for (genvar k = 0; k < CYC_W; k++) begin : g_bit
        localparam int POS = CYC_W - 1 - k;
        localparam logic [CYC_W-1:0] LOW_MASK = CYC_W'((1 << POS) - 1);
        assign hit[k] = brm[k] & cyc[POS] & ~|(cyc & LOW_MASK);
    end

    assign stretch = |hit;

endmodule

// File: rtl/pwm_brm.sv
module pwm_brm #(
    parameter int CNT_W = 8,
    parameter int CYC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out
);

    logic [CNT_W-1:0] cnt;
    logic [CYC_W-1:0] cyc;
    logic             last_clk;
    logic [CNT_W-1:0] duty_q;
    logic [CYC_W-1:0] brm_q;
    logic             stretch;
    logic [CNT_W:0]   on_len;

    pwm_brm_timebase #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .cyc      (cyc),
        .last_clk (last_clk)
    );

    pwm_brm_loader #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_ld (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .last_clk (last_clk),
        .duty_q   (duty_q),
        .brm_q    (brm_q)
    );

    pwm_brm_pattern #(.CYC_W(CYC_W)) u_pat (
        .cyc     (cyc),
        .brm     (brm_q),
        .stretch (stretch)
    );

    assign on_len  = {1'b0, duty_q} + {{CNT_W{1'b0}}, stretch};
    assign pwm_out = ({1'b0, cnt} < on_len);

endmodule

// File: rtl/pwm_brm_chk.sv
module pwm_brm_chk #(
    parameter int CNT_W = 8,
    parameter int CYC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CYC_W-1:0] cyc,
    input logic [CNT_W-1:0] duty_q,
    input logic [CYC_W-1:0] brm_q,
    input logic             pwm_out
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != CNT_MAX) |=> ($stable(duty_q) && $stable(brm_q)));

    // R5
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cyc == $past(cyc) + 1'b1));

    // R3
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0 && brm_q == '0) |-> !pwm_out);

    // R2
    first_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && duty_q != '0) |-> pwm_out);

    // R4
    cyc0_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == '0 && cnt == duty_q) |-> !pwm_out);

    // R9
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == CNT_MAX && brm_q[CYC_W-1] && cyc[0]) |-> pwm_out);

endmodule

bind pwm_brm pwm_brm_chk #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt),
    .cyc     (cyc),
    .duty_q  (duty_q),
    .brm_q   (brm_q),
    .pwm_out (pwm_out)
);

// File: tb/tb_pwm_brm.sv
`timescale 1ns/1ps
module tb_pwm_brm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       pwm_out;

    int total = 0;
    int bad = 0;
    int tick = 0;
    bit done = 1'b0;
    string tag = "R1";

    int m_duty = 0, m_brm = 0, p_duty = 0, p_brm = 0, m_buf = 0;
    bit armed = 1'b0;
    int cyc_err = 0, err_act = 0, err_exp = 0, err_k = 0;

    always #5 clk = ~clk;

    pwm_brm dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    function automatic int exp_stretch(int brm, int c);
        int tz = 0;
        int v = c;
        if (v == 0) return 0;
        while (v % 2 == 0) begin
            v = v / 2;
            tz++;
        end
        return (brm >> (5 - tz)) & 1;
    endfunction

    // sample current tick, apply optional write, advance model and clock
    task automatic step(input bit do_wr, input bit sel, input int data);
        int k = tick % 256;
        int c = (tick / 256) % 64;
        int on = m_duty + exp_stretch(m_brm, c);
        bit exp = (k < on);
        if (pwm_out !== exp && cyc_err == 0) begin
            err_act = pwm_out;
            err_exp = exp;
            err_k = k;
        end
        if (pwm_out !== exp) cyc_err++;
        wr_en = do_wr;
        wr_sel = sel;
        wr_data = data[7:0];
        if (do_wr && sel) m_buf = data & 63;
        if (do_wr && !sel) begin
            p_duty = data & 255;
            p_brm = m_buf;
            armed = 1'b1;
        end
        if (k == 255) begin
            if (armed) begin
                m_duty = p_duty;
                m_brm = p_brm;
                armed = 1'b0;
            end
            total++;
            if (cyc_err != 0) begin
                bad++;
                $display("FAIL %s cycle %0d clk %0d actual=%0d expected=%0d", tag, c, err_k, err_act, err_exp);
            end
            cyc_err = 0;
        end
        tick++;
        @(negedge clk);
    endtask

    task automatic idle_to(input int target_k);
        while (tick % 256 != target_k) step(1'b0, 1'b0, 0);
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n * 256; i++) step(1'b0, 1'b0, 0);
    endtask

    // load fine value then coarse value at clock 10 of a cycle
    task automatic load(input int duty, input int fine);
        idle_to(8);
        step(1'b1, 1'b1, fine);
        step(1'b0, 1'b0, 0);
        step(1'b1, 1'b0, duty);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: output low while in reset
        total++;
        if (pwm_out !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset actual=%0d expected=0", pwm_out);
        end
        rst_n = 1'b1;

        tag = "R1";
        run_cycles(2);

        // R6: fine-only write leaves output untouched
        tag = "R6";
        idle_to(50);
        step(1'b1, 1'b1, 63);
        run_cycles(1);

        // R7: coarse write mid-cycle, remainder of cycle unchanged
        tag = "R7";
        idle_to(100);
        step(1'b1, 1'b0, 64);
        run_cycles(3);

        // R2: plain coarse duty
        tag = "R2";
        load(128, 0);
        run_cycles(3);

        // R4: each fine bit alone over a full frame
        tag = "R4";
        for (int b = 0; b < 6; b++) begin
            load(20, 1 << b);
            run_cycles(64);
        end

        // R3 R5: zero coarse with stretches, across the wrap
        tag = "R3 R5";
        load(0, 33);
        run_cycles(70);

        // R9: full-scale coarse with all fine bits
        tag = "R9";
        load(255, 63);
        run_cycles(4);

        // R8: coarse write on the last clock of a cycle
        tag = "R8";
        idle_to(255);
        step(1'b1, 1'b0, 77);
        run_cycles(2);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule